// File: doc/BRIEF.md
# Per-Lane DC-Balance Word Encoder

This block sits in front of the bit serializers of a multi-lane parallel-to-serial link. Every cycle it receives one narrow data word for each lane. For each lane it decides whether that word goes out as it is or with every bit inverted. It attaches one balance flag bit per lane so the far end can undo the inversion. The decision keeps the long-term count of ones and zeros on each serial line close to even, which limits baseline wander and inter-symbol interference on long cables.

Each lane tracks its own running disparity. The running disparity is updated by the net ones-minus-zeros of the transmitted word together with its flag bit, and it is clamped to an asymmetric window of +7 to -6. When the balance enable input is low, the block passes the words through untouched, with every flag at 0 and every running disparity frozen. This lets the link talk to older receivers that have no balance bit. Encoded words, flags and a valid strobe are all registered, one cycle after the input.

Top module: `dcb_encoder`

## Requirements
- R1: For lane i, the encoded word occupies out_data[i*WORD_W +: WORD_W] and its flag is out_flag[i]. A flag of 0 means the word is the input word unchanged. A flag of 1 means the word is the bitwise inverse of the input word.
- R2: The word disparity is the number of 1 bits minus the number of 0 bits in the input word. When balancing, if the lane's running disparity is greater than 0 and the word disparity is greater than 0, the word is sent inverted.
- R3: When balancing, if the running disparity is 0 or less and the word disparity is less than 0, the word is sent inverted. In every other case, including a word disparity of exactly 0, the word is sent unchanged.
- R4: When a word is sent unchanged, the running disparity gains (word disparity - 1). When a word is sent inverted, it gains (1 - word disparity).
- R5: The running disparity never rises above +7 and never falls below -6. A sum outside that range is clamped to the nearest limit.
- R6: With bal_en low, every lane outputs its input word unchanged with a flag of 0, and no running disparity changes.
- R7: Reset (rst_n low, asynchronous) clears every running disparity to 0 and drives out_valid, out_flag and out_data to 0.
- R8: out_valid equals in_valid delayed by one clock. A cycle with in_valid low changes no running disparity, no output word and no flag.
- R9: Each lane's decision and running disparity depend only on that lane's own words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bal_en | input | 1 | 1 = balance and flag words, 0 = raw pass-through |
| in_valid | input | 1 | Input words present this cycle |
| in_data | input | NUM_LANES*WORD_W | Lane words, lane i at bits [i*WORD_W +: WORD_W] |
| out_valid | output | 1 | Registered valid strobe |
| out_data | output | NUM_LANES*WORD_W | Encoded lane words |
| out_flag | output | NUM_LANES | Balance flag per lane, 1 = inverted |

## Verification
The assertions assume that in_data, in_valid and bal_en are never unknown while reset is released, and that reset is held across at least one clock edge. They allow bal_en and in_valid to change on any cycle. The bench meets these assumptions by driving every input on the falling clock edge from known values, and by keeping in_valid low for the whole of reset. Random words are skewed toward all-ones, all-zeros and balanced patterns. This makes both clamp limits and the zero-disparity rule occur often, while a mode toggle and idle gaps appear between them.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

   // Saturation window of the running disparity
   localparam int DCB_DISP_HI = 7;
   localparam int DCB_DISP_LO = -6;

   // Meaning of the per-lane balance flag
   typedef enum logic {
      DCB_SENT_PLAIN  = 1'b0,
      DCB_SENT_INVERT = 1'b1
   } dcb_choice_e;

   // Signed width able to hold running value plus any single-word step
   function automatic int dcb_sum_width(input int word_w, input int hi, input int lo);
      return $clog2(hi - lo + 2 * word_w + 4) + 1;
   endfunction

endpackage

// File: rtl/dcb_popcount.sv
module dcb_popcount #(
   parameter int WORD_W = 6,
   parameter int SW     = 6
) (
   input  logic [WORD_W-1:0]    word_i,
   output logic signed [SW-1:0] disp_o
);

   localparam logic [SW-1:0] WORD_W_V = SW'(WORD_W);

   logic [SW-1:0] ones;

   // ones minus zeros = 2*ones - width
   always_comb begin
      ones = '0;
      for (int b = 0; b < WORD_W; b++) begin
         ones = ones + SW'(word_i[b]);
      end
      disp_o = $signed(ones + ones) - $signed(WORD_W_V);
   end

endmodule

// File: rtl/dcb_sat.sv
module dcb_sat #(
   parameter int SW = 6,
   parameter int HI = 7,
   parameter int LO = -6
) (
   input  logic signed [SW-1:0] sum_i,
   output logic signed [SW-1:0] sat_o
);

   localparam logic signed [SW-1:0] HI_V = SW'(HI);
   localparam logic signed [SW-1:0] LO_V = SW'(LO);

   generate
      if (HI == -LO) begin : g_sym
         // symmetric window: one magnitude compare against HI
         always_comb begin
            if (sum_i > HI_V)       sat_o = HI_V;
            else if (sum_i < -HI_V) sat_o = LO_V;
            else                    sat_o = sum_i;
         end
      end else begin : g_asym
         always_comb begin
            if (sum_i > HI_V)      sat_o = HI_V;
            else if (sum_i < LO_V) sat_o = LO_V;
            else                   sat_o = sum_i;
         end
      end
   endgenerate

endmodule

// File: rtl/dcb_lane.sv
module dcb_lane
   import dcb_pkg::*;
#(
   parameter int WORD_W = 6,
   parameter int SW     = 6,
   parameter int HI     = DCB_DISP_HI,
   parameter int LO     = DCB_DISP_LO
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bal_en_i,
   input  logic              valid_i,
   input  logic [WORD_W-1:0] data_i,
   output logic [WORD_W-1:0] data_o,
   output logic              flag_o
);

   localparam logic signed [SW-1:0] ONE_V = SW'(1);
   localparam logic signed [SW-1:0] HI_V  = SW'(HI);
   localparam logic signed [SW-1:0] LO_V  = SW'(LO);

   logic signed [SW-1:0] word_disp;
   logic signed [SW-1:0] rd_q;
   logic signed [SW-1:0] step;
   logic signed [SW-1:0] rd_sum;
   logic signed [SW-1:0] rd_nxt;
   dcb_choice_e          choice;

   dcb_popcount #(.WORD_W(WORD_W), .SW(SW)) u_pop (
      .word_i (data_i),
      .disp_o (word_disp)
   );

   // polarity choice from running and word disparity signs
   always_comb begin
      if (((rd_q > 0) && (word_disp > 0)) || ((rd_q <= 0) && (word_disp < 0)))
         choice = DCB_SENT_INVERT;
      else
         choice = DCB_SENT_PLAIN;
   end

   // step includes the flag bit: plain adds d-1, inverted adds 1-d
   always_comb begin
      if (choice == DCB_SENT_INVERT) step = ONE_V - word_disp;
      else                           step = word_disp - ONE_V;
      rd_sum = rd_q + step;
   end

   dcb_sat #(.SW(SW), .HI(HI), .LO(LO)) u_sat (
      .sum_i (rd_sum),
      .sat_o (rd_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= '0;
         data_o <= '0;
         flag_o <= 1'b0;
      end else if (valid_i) begin
         if (bal_en_i) begin
            data_o <= (choice == DCB_SENT_INVERT) ? ~data_i : data_i;
            flag_o <= (choice == DCB_SENT_INVERT);
            rd_q   <= rd_nxt;
         end else begin
            data_o <= data_i;
            flag_o <= 1'b0;
         end
      end
   end

   p_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_q <= HI_V) && (rd_q >= LO_V));

   p_pos_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && bal_en_i && (rd_q > 0) && (word_disp > 0)) |=> flag_o);

   p_neg_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && bal_en_i && (rd_q <= 0) && (word_disp < 0)) |=> flag_o);

   p_zero_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && bal_en_i && (word_disp == 0)) |=> !flag_o);

   p_restore_r1: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> ((data_o ^ {WORD_W{flag_o}}) == $past(data_i)));

   p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !bal_en_i) |=> (!flag_o && (data_o == $past(data_i)) && $stable(rd_q)));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> ($stable(rd_q) && $stable(data_o) && $stable(flag_o)));

endmodule

// File: rtl/dcb_encoder.sv
module dcb_encoder
   import dcb_pkg::*;
#(
   parameter int NUM_LANES = 8,
   parameter int WORD_W    = 6,
   parameter int DISP_HI   = DCB_DISP_HI,
   parameter int DISP_LO   = DCB_DISP_LO
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bal_en,
   input  logic                          in_valid,
   input  logic [NUM_LANES*WORD_W-1:0]   in_data,
   output logic                          out_valid,
   output logic [NUM_LANES*WORD_W-1:0]   out_data,
   output logic [NUM_LANES-1:0]          out_flag
);

   localparam int SW = dcb_sum_width(WORD_W, DISP_HI, DISP_LO);

   generate
      if (NUM_LANES < 1) begin : g_chk_lanes
         $error("dcb_encoder: NUM_LANES must be at least 1");
      end
      if (WORD_W < 1) begin : g_chk_width
         $error("dcb_encoder: WORD_W must be at least 1");
      end
      if (DISP_HI <= 0 || DISP_LO >= 0) begin : g_chk_window
         $error("dcb_encoder: window needs DISP_HI > 0 > DISP_LO");
      end
      if (2 * WORD_W >= (1 << (SW - 1))) begin : g_chk_sw
         $error("dcb_encoder: internal sum width too small");
      end
   endgenerate

   generate
      for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
         dcb_lane #(
            .WORD_W (WORD_W),
            .SW     (SW),
            .HI     (DISP_HI),
            .LO     (DISP_LO)
         ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .bal_en_i (bal_en),
            .valid_i  (in_valid),
            .data_i   (in_data[ln*WORD_W +: WORD_W]),
            .data_o   (out_data[ln*WORD_W +: WORD_W]),
            .flag_o   (out_flag[ln])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   p_valid_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_bypass_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !bal_en) |=> (out_flag == '0));

endmodule

// File: tb/sim_dcb_encoder.sv
`timescale 1ns/1ps
module sim_dcb_encoder;

   localparam int L = 8;
   localparam int W = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bal_en = 1'b0;
   logic           in_valid = 1'b0;
   logic [L*W-1:0] in_data = '0;
   logic           out_valid;
   logic [L*W-1:0] out_data;
   logic [L-1:0]   out_flag;

   always #2.5 clk = ~clk;

   dcb_encoder #(.NUM_LANES(L), .WORD_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .bal_en(bal_en), .in_valid(in_valid),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
      .out_flag(out_flag)
   );

   int             total = 0;
   int             bad = 0;
   int             rd_m [L];
   logic           exp_v = 1'b0;
   logic [L*W-1:0] exp_d = '0;
   logic [L-1:0]   exp_f = '0;
   logic [L*W-1:0] exp_in = '0;
   string          ph = "R7";

   function automatic int ones_of(input logic [W-1:0] w);
      int n = 0;
      for (int b = 0; b < W; b++) n += int'(w[b]);
      return n;
   endfunction

   function automatic logic [L*W-1:0] rep(input logic [W-1:0] w);
      return {L{w}};
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
      end
   endtask

   task automatic check_outputs();
      chk(out_valid == exp_v, (ph == "R7") ? "R8" : ph, "out_valid", longint'(out_valid), longint'(exp_v));
      for (int l = 0; l < L; l++) begin
         chk(out_data[l*W +: W] == exp_d[l*W +: W], ph, $sformatf("lane%0d word", l),
             longint'(out_data[l*W +: W]), longint'(exp_d[l*W +: W]));
         chk(out_flag[l] == exp_f[l], ph, $sformatf("lane%0d flag", l),
             longint'(out_flag[l]), longint'(exp_f[l]));
         if (exp_v)  // R1: receive-side restore
            chk((out_data[l*W +: W] ^ {W{out_flag[l]}}) == exp_in[l*W +: W], "R1",
                $sformatf("lane%0d restore", l),
                longint'(out_data[l*W +: W] ^ {W{out_flag[l]}}), longint'(exp_in[l*W +: W]));
      end
   endtask

   // Reference model from R2..R6, R8
   task automatic step(input bit v, input bit b, input logic [L*W-1:0] d);
      @(negedge clk);
      check_outputs();
      in_valid = v;
      bal_en   = b;
      in_data  = d;
      exp_v    = v;
      if (v) begin
         exp_in = d;
         for (int l = 0; l < L; l++) begin
            logic [W-1:0] w;
            int dd;
            bit inv;
            w = d[l*W +: W];
            if (!b) begin
               exp_d[l*W +: W] = w;
               exp_f[l] = 1'b0;
            end else begin
               dd  = 2 * ones_of(w) - W;
               inv = ((rd_m[l] > 0) && (dd > 0)) || ((rd_m[l] <= 0) && (dd < 0));
               exp_d[l*W +: W] = inv ? ~w : w;
               exp_f[l] = inv;
               rd_m[l] += inv ? (1 - dd) : (dd - 1);
               if (rd_m[l] > 7)  rd_m[l] = 7;
               if (rd_m[l] < -6) rd_m[l] = -6;
            end
         end
      end
   endtask

   function automatic logic [W-1:0] rnd_word();
      case ($urandom % 5)
         0: return '1;
         1: return '0;
         2: return W'(6'b000111);
         default: return W'($urandom);
      endcase
   endfunction

   initial begin
      for (int l = 0; l < L; l++) rd_m[l] = 0;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      ph = "R7";
      chk(out_valid == 1'b0, "R7", "reset valid", longint'(out_valid), 0);
      chk(out_flag == '0, "R7", "reset flags", longint'(out_flag), 0);
      chk(out_data == '0, "R7", "reset data", longint'(out_data), 0);
      rst_n = 1'b1;
      step(0, 1, '0);

      ph = "R2";                              // all ones: plain, inverted, ...
      repeat (4) step(1, 1, rep('1));
      ph = "R3";                              // all zeros after rd back to 0
      repeat (4) step(1, 1, rep('0));
      ph = "R5";                              // balanced words drive rd to -6 floor
      repeat (10) step(1, 1, rep(W'(6'b010101)));
      step(1, 1, rep('1));
      repeat (4) step(1, 1, rep(W'(6'b001111)));
      ph = "R9";                              // distinct pattern per lane
      for (int k = 0; k < 12; k++) begin
         logic [L*W-1:0] d;
         for (int l = 0; l < L; l++) d[l*W +: W] = W'((k * 7 + l * 13) ^ (l << 2));
         step(1, 1, d);
      end
      ph = "R6";                              // bypass then resume
      repeat (6) step(1, 0, {$urandom, $urandom});
      repeat (4) step(1, 1, rep(W'(6'b000001)));
      ph = "R8";                              // idle gaps
      step(1, 1, rep(W'(6'b110111)));
      repeat (3) step(0, 1, {$urandom, $urandom});
      step(1, 1, rep(W'(6'b100000)));
      step(0, 0, '1);

      ph = "R4";                              // random mix
      for (int it = 0; it < 1500; it++) begin
         logic [L*W-1:0] d;
         for (int l = 0; l < L; l++) d[l*W +: W] = rnd_word();
         step(($urandom % 4) != 0, ($urandom % 8) != 0, d);
      end
      @(negedge clk);
      check_outputs();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule